// File: doc/BRIEF.md
# Interrupt Number Resolver

This block turns three pending-interrupt words into the one interrupt number a processor should service next. Its inputs are a 21-bit summary word and two 32-bit bank words. It searches them in a fixed order and registers the result as a 7-bit global number with a valid flag. Software reads a single value instead of scanning three words and sorting out the mirrored bits itself.

The summary word has several fields. Its low eight bits are direct sources. Bits 10 to 20 mirror selected bank sources, called shortcuts: bits 10 to 14 stand for low-bank sources 7, 9, 10, 18 and 19, and bits 15 to 20 stand for high-bank sources 21, 22, 23, 24, 25 and 30. Bits 8 and 9 flag that the low bank or the high bank has something pending.

Global numbering is laid out as follows:
- Direct sources take numbers 0 to 7.
- The low bank takes numbers 8 to 39.
- The high bank takes numbers 40 to 71.

A separate combinational translator turns a bank code and an index within that bank into a global number. It checks the range, so that configuration code can validate a source before using it.

Top module: `irq_resolver`

## Requirements
- R1: When the summary word is zero, `valid_o` is 0 one cycle later.
- R2: If any summary bit 0..7 is set, the result is the position of the lowest set bit among them, whatever else is pending.
- R3: Otherwise, if any summary bit 10..14 is set, the lowest such bit k selects low-bank source L[k-10], where L = (7, 9, 10, 18, 19). The result is 8 + L[k-10].
- R4: Otherwise, if any summary bit 15..20 is set, the lowest such bit k selects high-bank source H[k-15], where H = (21, 22, 23, 24, 25, 30). The result is 40 + H[k-15].
- R5: Otherwise, if summary bit 8 is set and the low-bank word with bits 7, 9, 10, 18 and 19 cleared is non-zero, the result is 8 + the position of its lowest set bit.
- R6: Otherwise, if summary bit 9 is set and the high-bank word with bits 21..25 and 30 cleared is non-zero, the result is 40 + the position of its lowest set bit. This step is also reached when bit 8 is set but the masked low-bank word is empty.
- R7: If no step above finds a source, `valid_o` is 0 even with a non-zero summary word.
- R8: Result and flag are registered. They change only at the clock edge after the inputs change. After reset they are `valid_o`=0 and `num_o`=0x7F.
- R9: Whenever `valid_o` is 0, `num_o` reads 0x7F.
- R10: The translator maps bank code 0 with index i to number i, and reports it valid only when i < 8.
- R11: The translator handles the other bank codes as follows:
  - Code 1 maps index i to i+8, valid only when i+8 ≤ 39.
  - Code 2 maps index i to i+40, valid only when i+40 ≤ 71.
  - Code 3 is always invalid.
  - Whenever the translator reports invalid, its number output is 0x7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| basic_pend_i | input | 21 | Summary pending word |
| bank1_pend_i | input | 32 | Low-bank pending word |
| bank2_pend_i | input | 32 | High-bank pending word |
| num_o | output | 7 | Registered global interrupt number |
| valid_o | output | 1 | Registered result valid |
| cfg_bank_i | input | 2 | Translator bank code |
| cfg_index_i | input | 6 | Translator index within bank |
| cfg_num_o | output | 7 | Translated global number |
| cfg_ok_o | output | 1 | Translation in range |

## Verification
The hardest case to reach is the fall-through inside the bank search. Summary bit 8 is set, but the low bank holds only sources that are also mirrored as shortcuts, so masking leaves nothing. The result must then come from the high bank, or be invalid. The stimulus builds this case on purpose: it sets summary bits 8 and 9 with a low-bank word made only of shortcut positions and a clear shortcut field. Random cycles then mix fields, and one third of them restrict the bank words to shortcut positions. A behavioural model in the bench, written from the ordered source lists, is compared against the outputs on every cycle.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int BASIC_W  = 21;
  localparam int BANK_W   = 32;
  localparam int NUM_W    = 7;
  localparam int IDX_W    = 6;
  localparam int N_DIRECT = 8;
  localparam int B1_BASE  = N_DIRECT;
  localparam int B2_BASE  = B1_BASE + BANK_W;
  localparam int N_TOTAL  = B2_BASE + BANK_W;
  localparam int B1_FLAG  = 8;
  localparam int B2_FLAG  = 9;
  localparam int N_SC1    = 5;
  localparam int N_SC2    = 6;
  localparam int SC1_LSB  = 10;
  localparam int SC2_LSB  = SC1_LSB + N_SC1;
  localparam logic [NUM_W-1:0] NONE = {NUM_W{1'b1}};

  typedef enum logic [1:0] {
    BK_DIRECT = 2'd0,
    BK_LOW    = 2'd1,
    BK_HIGH   = 2'd2,
    BK_RSVD   = 2'd3
  } bank_code_e;

  // shortcut slot -> bank source, in search order
  function automatic int sc1_src(int k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      default: return 19;
    endcase
  endfunction

  function automatic int sc2_src(int k);
    case (k)
      0: return 21;
      1: return 22;
      2: return 23;
      3: return 24;
      4: return 25;
      default: return 30;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] sc1_mask();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int k = 0; k < N_SC1; k++) m[sc1_src(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [BANK_W-1:0] sc2_mask();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int k = 0; k < N_SC2; k++) m[sc2_src(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_lowbit.sv
module irq_lowbit #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = |vec_i;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    if (hit_o) assert (vec_i[idx_o]) else $error("lowbit index not set");
  end
endmodule

// File: rtl/irq_shortcut_pick.sv
module irq_shortcut_pick #(
  parameter int N    = 5,
  parameter int BASE = 8,
  parameter bit HIGH = 1'b0
) (
  input  logic [N-1:0]                    sc_i,
  output logic                            hit_o,
  output logic [irq_res_pkg::NUM_W-1:0]   num_o
);
  import irq_res_pkg::*;
  localparam int IW = $clog2(N);

  logic [IW-1:0] slot;
  int            src;

  irq_lowbit #(.W(N), .IDX_W(IW)) u_low (
    .vec_i (sc_i),
    .hit_o (hit_o),
    .idx_o (slot)
  );

  generate
    if (HIGH) begin : g_high
      always_comb src = sc2_src(int'(slot));
    end else begin : g_low
      always_comb src = sc1_src(int'(slot));
    end
  endgenerate

  assign num_o = hit_o ? NUM_W'(BASE + src) : NONE;
endmodule

// File: rtl/irq_bank_pick.sv
module irq_bank_pick #(
  parameter int                               BASE = 8,
  parameter logic [irq_res_pkg::BANK_W-1:0]   MASK = '0
) (
  input  logic                            flag_i,
  input  logic [irq_res_pkg::BANK_W-1:0]  pend_i,
  output logic                            hit_o,
  output logic [irq_res_pkg::NUM_W-1:0]   num_o
);
  import irq_res_pkg::*;
  localparam int IW = $clog2(BANK_W);

  logic [BANK_W-1:0] masked;
  logic              any;
  logic [IW-1:0]     idx;

  assign masked = flag_i ? (pend_i & ~MASK) : '0;

  irq_lowbit #(.W(BANK_W), .IDX_W(IW)) u_low (
    .vec_i (masked),
    .hit_o (any),
    .idx_o (idx)
  );

  assign hit_o = any;
  assign num_o = any ? NUM_W'(BASE + int'(idx)) : NONE;

  always_comb begin
    if (hit_o) assert (!MASK[num_o - NUM_W'(BASE)]) else $error("shortcut bit leaked");
  end
endmodule

// File: rtl/irq_cfg_xlate.sv
module irq_cfg_xlate (
  input  logic [1:0]                      bank_i,
  input  logic [irq_res_pkg::IDX_W-1:0]   index_i,
  output logic [irq_res_pkg::NUM_W-1:0]   num_o,
  output logic                            ok_o
);
  import irq_res_pkg::*;

  logic [NUM_W:0] sum;
  logic [NUM_W:0] lim;

  always_comb begin
    sum = '0;
    lim = '0;
    ok_o = 1'b0;
    unique case (bank_code_e'(bank_i))
      BK_DIRECT: begin sum = (NUM_W+1)'(index_i);           lim = (NUM_W+1)'(B1_BASE - 1); ok_o = 1'b1; end
      BK_LOW:    begin sum = (NUM_W+1)'(index_i) + B1_BASE; lim = (NUM_W+1)'(B2_BASE - 1); ok_o = 1'b1; end
      BK_HIGH:   begin sum = (NUM_W+1)'(index_i) + B2_BASE; lim = (NUM_W+1)'(N_TOTAL - 1); ok_o = 1'b1; end
      default:   ok_o = 1'b0;
    endcase
    if (sum > lim) ok_o = 1'b0;
    num_o = ok_o ? sum[NUM_W-1:0] : NONE;
  end

  // R11: an accepted number never leaves the global range
  always_comb begin
    if (ok_o) assert (int'(num_o) < N_TOTAL) else $error("p_xlate_range_r11");
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BASIC_W-1:0]   basic_pend_i,
  input  logic [BANK_W-1:0]    bank1_pend_i,
  input  logic [BANK_W-1:0]    bank2_pend_i,
  output logic [NUM_W-1:0]     num_o,
  output logic                 valid_o,
  input  logic [1:0]           cfg_bank_i,
  input  logic [IDX_W-1:0]     cfg_index_i,
  output logic [NUM_W-1:0]     cfg_num_o,
  output logic                 cfg_ok_o
);
  localparam logic [BANK_W-1:0] M1 = sc1_mask();
  localparam logic [BANK_W-1:0] M2 = sc2_mask();
  localparam int DIW = $clog2(N_DIRECT);

  logic             dir_hit, sc1_hit, sc2_hit, bk1_hit, bk2_hit;
  logic [DIW-1:0]   dir_idx;
  logic [NUM_W-1:0] sc1_num, sc2_num, bk1_num, bk2_num;
  logic [NUM_W-1:0] nxt_num;
  logic             nxt_valid;

  irq_lowbit #(.W(N_DIRECT), .IDX_W(DIW)) u_direct (
    .vec_i (basic_pend_i[N_DIRECT-1:0]),
    .hit_o (dir_hit),
    .idx_o (dir_idx)
  );

  irq_shortcut_pick #(.N(N_SC1), .BASE(B1_BASE), .HIGH(1'b0)) u_sc1 (
    .sc_i  (basic_pend_i[SC1_LSB +: N_SC1]),
    .hit_o (sc1_hit),
    .num_o (sc1_num)
  );

  irq_shortcut_pick #(.N(N_SC2), .BASE(B2_BASE), .HIGH(1'b1)) u_sc2 (
    .sc_i  (basic_pend_i[SC2_LSB +: N_SC2]),
    .hit_o (sc2_hit),
    .num_o (sc2_num)
  );

  irq_bank_pick #(.BASE(B1_BASE), .MASK(M1)) u_bk1 (
    .flag_i (basic_pend_i[B1_FLAG]),
    .pend_i (bank1_pend_i),
    .hit_o  (bk1_hit),
    .num_o  (bk1_num)
  );

  irq_bank_pick #(.BASE(B2_BASE), .MASK(M2)) u_bk2 (
    .flag_i (basic_pend_i[B2_FLAG]),
    .pend_i (bank2_pend_i),
    .hit_o  (bk2_hit),
    .num_o  (bk2_num)
  );

  // fixed search order: direct, low shortcuts, high shortcuts, low bank, high bank
  always_comb begin
    nxt_valid = 1'b1;
    if (dir_hit)      nxt_num = NUM_W'(dir_idx);
    else if (sc1_hit) nxt_num = sc1_num;
    else if (sc2_hit) nxt_num = sc2_num;
    else if (bk1_hit) nxt_num = bk1_num;
    else if (bk2_hit) nxt_num = bk2_num;
    else begin
      nxt_valid = 1'b0;
      nxt_num   = NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_o   <= NONE;
      valid_o <= 1'b0;
    end else begin
      num_o   <= nxt_num;
      valid_o <= nxt_valid;
    end
  end

  irq_cfg_xlate u_xlate (
    .bank_i  (cfg_bank_i),
    .index_i (cfg_index_i),
    .num_o   (cfg_num_o),
    .ok_o    (cfg_ok_o)
  );

  logic no_early, m1_any, m2_any;
  assign no_early = (basic_pend_i[7:0] == '0) && (basic_pend_i[20:10] == '0);
  assign m1_any   = basic_pend_i[B1_FLAG] && ((bank1_pend_i & ~M1) != '0);
  assign m2_any   = basic_pend_i[B2_FLAG] && ((bank2_pend_i & ~M2) != '0);

  p_none_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> num_o == NONE);
  p_zero_basic_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    basic_pend_i == '0 |=> !valid_o);
  p_direct_win_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    basic_pend_i[7:0] != '0 |=> valid_o && num_o < 7'd8);
  p_sc1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (basic_pend_i[7:0] == '0 && basic_pend_i[14:10] != '0) |=>
      valid_o && (num_o == 7'd15 || num_o == 7'd17 || num_o == 7'd18 ||
                  num_o == 7'd26 || num_o == 7'd27));
  p_sc2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (basic_pend_i[14:0] == 15'h0 && basic_pend_i[20:15] != '0) |=>
      valid_o && num_o >= 7'd61 && (num_o <= 7'd65 || num_o == 7'd70));
  p_bank1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_early && m1_any) |=> valid_o && num_o >= 7'd8 && num_o <= 7'd39);
  p_bank2_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_early && !m1_any && m2_any) |=> valid_o && num_o >= 7'd40 && num_o <= 7'd71);
  p_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_early && !m1_any && !m2_any) |=> !valid_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(basic_pend_i) && $stable(bank1_pend_i) && $stable(bank2_pend_i) |=>
      $stable(num_o) && $stable(valid_o));
endmodule

// File: tb/sim_irq_resolver.sv
`timescale 1ns/1ps
module sim_irq_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] basic = '0;
  logic [31:0] p1 = '0, p2 = '0;
  logic [6:0]  num;
  logic        valid;
  logic [1:0]  cbank = '0;
  logic [5:0]  cidx = '0;
  logic [6:0]  cnum;
  logic        cok;

  int checks = 0, failures = 0;
  int exp_n = -1;
  string exp_tag = "R8";
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_resolver u0 (
    .clk_i(clk), .rst_ni(rst_n), .basic_pend_i(basic), .bank1_pend_i(p1),
    .bank2_pend_i(p2), .num_o(num), .valid_o(valid), .cfg_bank_i(cbank),
    .cfg_index_i(cidx), .cfg_num_o(cnum), .cfg_ok_o(cok));

  int l1[5] = '{7, 9, 10, 18, 19};
  int l2[6] = '{21, 22, 23, 24, 25, 30};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit listed(int v, bit hi);
    if (!hi) begin foreach (l1[k]) if (l1[k] == v) return 1; end
    else begin foreach (l2[k]) if (l2[k] == v) return 1; end
    return 0;
  endfunction

  function automatic void model(input logic [20:0] b, input logic [31:0] a1, a2,
                                output int n, output string tag);
    n = -1;
    tag = "R7";
    if (b == 0) begin tag = "R1"; return; end
    for (int i = 0; i < 8; i++) if (b[i]) begin n = i; tag = "R2"; return; end
    for (int k = 0; k < 5; k++) if (b[10+k]) begin n = 8 + l1[k]; tag = "R3"; return; end
    for (int k = 0; k < 6; k++) if (b[15+k]) begin n = 40 + l2[k]; tag = "R4"; return; end
    if (b[8]) for (int i = 0; i < 32; i++)
      if (a1[i] && !listed(i, 0)) begin n = 8 + i; tag = "R5"; return; end
    if (b[9]) for (int i = 0; i < 32; i++)
      if (a2[i] && !listed(i, 1)) begin n = 40 + i; tag = "R6"; return; end
  endfunction

  task automatic compare_out(string tag, int e);
    chk(tag, int'(valid), (e >= 0) ? 1 : 0);
    if (e >= 0) chk(tag, int'(num), e);
    else chk("R9", int'(num), 127);
  endtask

  // one cycle: check outputs from the previous inputs, apply new ones
  task automatic step(logic [20:0] b, logic [31:0] a1, logic [31:0] a2);
    @(negedge clk);
    compare_out(exp_tag, exp_n);
    basic = b; p1 = a1; p2 = a2;
    #1;
    compare_out("R8", exp_n);
    model(b, a1, a2, exp_n, exp_tag);
  endtask

  task automatic xl(logic [1:0] bk, int idx, int e, string tag);
    @(negedge clk);
    cbank = bk; cidx = 6'(idx);
    #1;
    chk(tag, int'(cok), (e >= 0) ? 1 : 0);
    chk(tag, int'(cnum), (e >= 0) ? e : 127);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_out("R8", -1);
    rst_n = 1'b1;
    step(21'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(21'h000F0, '0, '0);
    step(21'h1FFFFF, '1, '1);
    step(21'h05000, '0, '0);
    step(21'h105000, '0, '0);
    step(21'h100000, '0, '0);
    step(21'h090000, '0, '0);
    step(21'h00100, (32'h1 << 7) | (32'h1 << 20), '0);
    step(21'h00300, (32'h1 << 7) | (32'h1 << 19), 32'h8);
    step(21'h00200, '0, (32'h1 << 21) | (32'h1 << 31));
    step(21'h00200, '0, 32'h1);
    step(21'h00100, 32'h1 << 7, '0);
    step(21'h00200, '0, 32'h4200_0000);
    step(21'h00300, 32'h8000_0000, 32'h1);
    step(21'h00300, 32'h000C_0680, 32'h43E0_0000);
    for (int c = 0; c < 600; c++) begin
      logic [20:0] b;
      logic [31:0] a1, a2;
      a1 = $urandom; a2 = $urandom;
      case ($urandom % 4)
        0: b = 21'($urandom);
        1: b = 21'($urandom) & 21'h1FFC00;
        2: b = 21'($urandom) & 21'h000300;
        default: b = 21'($urandom) & 21'h1FFF00;
      endcase
      if ($urandom % 3 == 0) begin a1 &= 32'h000C_0680; a2 &= 32'h43E0_0000; end
      step(b, a1, a2);
    end
    step('0, '0, '0);
    step('0, '0, '0);
    xl(2'd0, 0, 0, "R10");
    xl(2'd0, 7, 7, "R10");
    xl(2'd0, 8, -1, "R10");
    xl(2'd1, 0, 8, "R11");
    xl(2'd1, 31, 39, "R11");
    xl(2'd1, 32, -1, "R11");
    xl(2'd2, 0, 40, "R11");
    xl(2'd2, 31, 71, "R11");
    xl(2'd2, 32, -1, "R11");
    xl(2'd3, 0, -1, "R11");
    xl(2'd3, 5, -1, "R11");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule